// File: doc/BRIEF.md
# Indexed and Auto-Increment Address Generator

This block is the address-generation stage of a load/store unit on a 64-bit core. Each cycle in which a request strobe is high it takes an operation code, an access size, the base and index register values, the immediate fields and the register numbers of the access. One cycle later it presents the effective address, a second address for paired accesses, a base-writeback value with its enable, and an illegal-encoding flag.

Three families of access are handled. Indexed accesses add a scaled index register, or only its zero-extended low half, to the base. Auto-increment accesses use a signed 5-bit immediate scaled by a 2-bit field. They access either the updated base (pre-increment) or the original base (post-increment), and in both cases they return the updated base for writeback. Paired accesses address two consecutive word or doubleword elements. Register conflicts that make an encoding illegal are flagged, and doubleword forms are rejected when the core runs in 32-bit mode. The memory port, alignment handling, load data extension and the register file lie outside this block.

Top module: `agu_idx_inc`

## Requirements
- R1: While reset is asserted and after it is released with no request, `vld_o`, `wb_en_o`, `pair_vld_o` and `illegal_o` are 0.
- R2: Every cycle with `req_valid_i` high produces exactly one cycle with `vld_o` high on the following clock edge. A cycle without a request gives `vld_o` low on the following edge.
- R3: For indexed ops (`op_i` 0 = indexed load, 1 = indexed store) with `zext_idx_i` low, `addr0_o` = `base_i` + (`index_i` << `scale_i`), computed modulo 2^64.
- R4: For indexed ops with `zext_idx_i` high, bits 63:32 of `index_i` are replaced by zero before the shift by `scale_i`.
- R5: For increment ops (`op_i` 2 = load, 3 = store), the offset is `inc_imm_i` sign-extended from 5 bits and shifted left by `scale_i`. `wb_data_o` = `base_i` + offset.
- R6: An increment op with `pre_inc_i` high gives `addr0_o` = `base_i` + offset. With `pre_inc_i` low it gives `addr0_o` = `base_i`.
- R7: An increment load with `rd_i` equal to `rs_base_i` sets `illegal_o`. An increment store with the same numbers is legal.
- R8: For paired ops (`op_i` 4 = load, 5 = store), with `size_i` 3 = doubleword and 2 = word, `addr0_o` = `base_i` + (`pair_imm_i` << 4) for doubleword or << 3 for word. `addr1_o` = `addr0_o` + 8 or + 4 respectively.
- R9: A paired load is illegal if `rs_base_i` equals `rd_i` or `rd2_i`, or if `rd_i` equals `rd2_i`. A paired store is legal whatever the register numbers are.
- R10: With `mode64_i` low, any op with `size_i` = 3 (doubleword) is illegal. Word and smaller sizes stay legal.
- R11: `wb_en_o` is high only for a legal increment op. `pair_vld_o` is high only for a legal paired op. `illegal_o` forces both low.
- R12: `op_i` codes 6 and 7 are illegal, and so is a paired op with `size_i` 0 (byte) or 1 (half).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| op_i | input | 3 | Operation: 0 idx load, 1 idx store, 2 inc load, 3 inc store, 4 pair load, 5 pair store |
| size_i | input | 2 | Access size: 0 byte, 1 half, 2 word, 3 doubleword |
| mode64_i | input | 1 | Core runs in 64-bit mode |
| zext_idx_i | input | 1 | Indexed: use zero-extended low 32 bits of the index |
| pre_inc_i | input | 1 | Increment: access at the updated base |
| base_i | input | 64 | Base register value |
| index_i | input | 64 | Index register value |
| scale_i | input | 2 | Shift amount for index or increment immediate |
| inc_imm_i | input | 5 | Signed increment immediate |
| pair_imm_i | input | 2 | Paired offset field |
| rd_i | input | 5 | Destination (or data) register number |
| rd2_i | input | 5 | Second destination register number for pairs |
| rs_base_i | input | 5 | Base register number |
| vld_o | output | 1 | Result valid |
| addr0_o | output | 64 | First effective address |
| addr1_o | output | 64 | Second address of a pair |
| pair_vld_o | output | 1 | Second address is to be used |
| wb_en_o | output | 1 | Base writeback enable |
| wb_data_o | output | 64 | Base writeback value |
| illegal_o | output | 1 | Illegal encoding |

## Verification
All results of a request (both addresses, writeback value and enable, pair valid and illegal flag) are due together on the first clock edge after the strobe. The bench samples 2 ns after each rising edge. The driver computes the expected result when it applies a request and queues it. The monitor pops one entry for each sampled cycle with `vld_o` high, so every result is compared in exactly the cycle after its strobe. An idle cycle checks that no result appears, and an empty queue at the end shows that no result was lost.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [2:0] {
    OP_IDX_LD  = 3'd0,
    OP_IDX_ST  = 3'd1,
    OP_INC_LD  = 3'd2,
    OP_INC_ST  = 3'd3,
    OP_PAIR_LD = 3'd4,
    OP_PAIR_ST = 3'd5
  } agu_op_e;

  localparam logic [1:0] SZ_B  = 2'd0;
  localparam logic [1:0] SZ_H  = 2'd1;
  localparam logic [1:0] SZ_W  = 2'd2;
  localparam logic [1:0] SZ_DW = 2'd3;
endpackage

// File: rtl/agu_idx_path.sv
module agu_idx_path #(
  parameter int XLEN  = 64,
  parameter int SCL_W = 2
) (
  input  logic [XLEN-1:0]  base_i,
  input  logic [XLEN-1:0]  index_i,
  input  logic             zext_i,
  input  logic [SCL_W-1:0] scale_i,
  output logic [XLEN-1:0]  addr_o
);
  localparam int HALF = XLEN / 2;

  logic [XLEN-1:0] idx_sel;

  always_comb begin
    idx_sel = zext_i ? {{(XLEN-HALF){1'b0}}, index_i[HALF-1:0]} : index_i;
    addr_o  = base_i + (idx_sel << scale_i);
  end
endmodule

// File: rtl/agu_inc_path.sv
module agu_inc_path #(
  parameter int XLEN  = 64,
  parameter int IMM_W = 5,
  parameter int SCL_W = 2
) (
  input  logic [XLEN-1:0]  base_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [SCL_W-1:0] scale_i,
  input  logic             pre_i,
  output logic [XLEN-1:0]  addr_o,
  output logic [XLEN-1:0]  wb_o
);
  logic [XLEN-1:0] imm_sx;
  logic [XLEN-1:0] upd;

  always_comb begin
    imm_sx = {{(XLEN-IMM_W){imm_i[IMM_W-1]}}, imm_i};
    upd    = base_i + (imm_sx << scale_i);
    wb_o   = upd;
    addr_o = pre_i ? upd : base_i;
  end
endmodule

// File: rtl/agu_pair_path.sv
module agu_pair_path #(
  parameter int XLEN   = 64,
  parameter int PIMM_W = 2
) (
  input  logic [XLEN-1:0]   base_i,
  input  logic [PIMM_W-1:0] pimm_i,
  input  logic              dword_i,
  output logic [XLEN-1:0]   addr0_o,
  output logic [XLEN-1:0]   addr1_o
);
  localparam int SH_W = 4;
  localparam int SH_W_ = 3;

  logic [XLEN-1:0] pimm_x;
  logic [XLEN-1:0] stride;

  always_comb begin
    pimm_x  = {{(XLEN-PIMM_W){1'b0}}, pimm_i};
    stride  = dword_i ? XLEN'(8) : XLEN'(4);
    addr0_o = base_i + (dword_i ? (pimm_x << SH_W) : (pimm_x << SH_W_));
    addr1_o = addr0_o + stride;
  end
endmodule

// File: rtl/agu_legal.sv
module agu_legal
  import agu_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [2:0]       op_i,
  input  logic [1:0]       size_i,
  input  logic             mode64_i,
  input  logic [REG_W-1:0] rd_i,
  input  logic [REG_W-1:0] rd2_i,
  input  logic [REG_W-1:0] rs_i,
  output logic             illegal_o
);
  logic dw_bad;
  logic pair_sz_bad;
  logic pair_clash;

  always_comb begin
    dw_bad      = (size_i == SZ_DW) && !mode64_i;
    pair_sz_bad = (size_i == SZ_B) || (size_i == SZ_H);
    pair_clash  = (rs_i == rd_i) || (rs_i == rd2_i) || (rd_i == rd2_i);
    case (op_i)
      OP_IDX_LD, OP_IDX_ST: illegal_o = dw_bad;
      OP_INC_LD:            illegal_o = dw_bad || (rd_i == rs_i);
      OP_INC_ST:            illegal_o = dw_bad;
      OP_PAIR_LD:           illegal_o = dw_bad || pair_sz_bad || pair_clash;
      OP_PAIR_ST:           illegal_o = dw_bad || pair_sz_bad;
      default:              illegal_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/agu_idx_inc.sv
module agu_idx_inc
  import agu_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int REG_W  = 5,
  parameter int IMM_W  = 5,
  parameter int PIMM_W = 2,
  parameter int SCL_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [2:0]        op_i,
  input  logic [1:0]        size_i,
  input  logic              mode64_i,
  input  logic              zext_idx_i,
  input  logic              pre_inc_i,
  input  logic [XLEN-1:0]   base_i,
  input  logic [XLEN-1:0]   index_i,
  input  logic [SCL_W-1:0]  scale_i,
  input  logic [IMM_W-1:0]  inc_imm_i,
  input  logic [PIMM_W-1:0] pair_imm_i,
  input  logic [REG_W-1:0]  rd_i,
  input  logic [REG_W-1:0]  rd2_i,
  input  logic [REG_W-1:0]  rs_base_i,
  output logic              vld_o,
  output logic [XLEN-1:0]   addr0_o,
  output logic [XLEN-1:0]   addr1_o,
  output logic              pair_vld_o,
  output logic              wb_en_o,
  output logic [XLEN-1:0]   wb_data_o,
  output logic              illegal_o
);
  logic [XLEN-1:0] idx_addr, inc_addr, inc_wb, pr_a0, pr_a1;
  logic            illegal;
  logic            is_inc, is_pair;
  logic [XLEN-1:0] addr0_d;

  agu_idx_path #(.XLEN(XLEN), .SCL_W(SCL_W)) u_idx (
    .base_i(base_i), .index_i(index_i), .zext_i(zext_idx_i),
    .scale_i(scale_i), .addr_o(idx_addr)
  );

  agu_inc_path #(.XLEN(XLEN), .IMM_W(IMM_W), .SCL_W(SCL_W)) u_inc (
    .base_i(base_i), .imm_i(inc_imm_i), .scale_i(scale_i),
    .pre_i(pre_inc_i), .addr_o(inc_addr), .wb_o(inc_wb)
  );

  agu_pair_path #(.XLEN(XLEN), .PIMM_W(PIMM_W)) u_pair (
    .base_i(base_i), .pimm_i(pair_imm_i), .dword_i(size_i == SZ_DW),
    .addr0_o(pr_a0), .addr1_o(pr_a1)
  );

  agu_legal #(.REG_W(REG_W)) u_legal (
    .op_i(op_i), .size_i(size_i), .mode64_i(mode64_i),
    .rd_i(rd_i), .rd2_i(rd2_i), .rs_i(rs_base_i), .illegal_o(illegal)
  );

  always_comb begin
    is_inc  = (op_i == OP_INC_LD) || (op_i == OP_INC_ST);
    is_pair = (op_i == OP_PAIR_LD) || (op_i == OP_PAIR_ST);
    if (is_inc)       addr0_d = inc_addr;
    else if (is_pair) addr0_d = pr_a0;
    else              addr0_d = idx_addr;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o      <= 1'b0;
      addr0_o    <= '0;
      addr1_o    <= '0;
      pair_vld_o <= 1'b0;
      wb_en_o    <= 1'b0;
      wb_data_o  <= '0;
      illegal_o  <= 1'b0;
    end else begin
      vld_o <= req_valid_i;
      if (req_valid_i) begin
        addr0_o    <= addr0_d;
        addr1_o    <= is_pair ? pr_a1 : '0;
        pair_vld_o <= is_pair && !illegal;
        wb_en_o    <= is_inc && !illegal;
        wb_data_o  <= is_inc ? inc_wb : '0;
        illegal_o  <= illegal;
      end else begin
        pair_vld_o <= 1'b0;
        wb_en_o    <= 1'b0;
        illegal_o  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/agu_idx_inc_chk.sv
module agu_idx_inc_chk #(
  parameter int XLEN = 64
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_valid_i,
  input logic [2:0]      op_i,
  input logic [1:0]      size_i,
  input logic            mode64_i,
  input logic            zext_idx_i,
  input logic            pre_inc_i,
  input logic [XLEN-1:0] base_i,
  input logic [XLEN-1:0] index_i,
  input logic [1:0]      scale_i,
  input logic [4:0]      rd_i,
  input logic [4:0]      rs_base_i,
  input logic            vld_o,
  input logic [XLEN-1:0] addr0_o,
  input logic [XLEN-1:0] addr1_o,
  input logic            pair_vld_o,
  input logic            wb_en_o,
  input logic [XLEN-1:0] wb_data_o,
  input logic            illegal_o
);
  a_r2_vld_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> vld_o);

  a_r2_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !vld_o);

  a_r3_idx_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_o && $past(op_i) <= 3'd1 && !$past(zext_idx_i))
      |-> addr0_o == $past(base_i) + ($past(index_i) << $past(scale_i)));

  a_r6_post_base: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_o && wb_en_o && !$past(pre_inc_i)) |-> addr0_o == $past(base_i));

  a_r6_pre_upd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_o && wb_en_o && $past(pre_inc_i)) |-> addr0_o == wb_data_o);

  a_r7_inc_ld_clash: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_o && $past(op_i) == 3'd2 && $past(rd_i) == $past(rs_base_i)) |-> illegal_o);

  a_r8_pair_stride: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pair_vld_o |-> (addr1_o - addr0_o == XLEN'(8)) || (addr1_o - addr0_o == XLEN'(4)));

  a_r10_dw_32bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_o && $past(size_i) == 2'd3 && !$past(mode64_i)) |-> illegal_o);

  a_r11_illegal_no_wb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !wb_en_o && !pair_vld_o);

  a_r11_flags_need_vld: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_en_o || pair_vld_o || illegal_o) |-> vld_o);

  a_r12_rsvd_op: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_o && $past(op_i) >= 3'd6) |-> illegal_o);
endmodule

bind agu_idx_inc agu_idx_inc_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/tb_agu_idx_inc.sv
`timescale 1ns/1ps
module tb_agu_idx_inc;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [1:0]  size_i = '0;
  logic        mode64_i = 1'b1;
  logic        zext_idx_i = 1'b0;
  logic        pre_inc_i = 1'b0;
  logic [63:0] base_i = '0;
  logic [63:0] index_i = '0;
  logic [1:0]  scale_i = '0;
  logic [4:0]  inc_imm_i = '0;
  logic [1:0]  pair_imm_i = '0;
  logic [4:0]  rd_i = '0;
  logic [4:0]  rd2_i = '0;
  logic [4:0]  rs_base_i = '0;
  logic        vld_o;
  logic [63:0] addr0_o;
  logic [63:0] addr1_o;
  logic        pair_vld_o;
  logic        wb_en_o;
  logic [63:0] wb_data_o;
  logic        illegal_o;

  agu_idx_inc dut (.*);

  always #4 clk_i = ~clk_i;

  typedef struct {
    logic [63:0] a0;
    logic [63:0] a1;
    logic [63:0] wb;
    logic        pv;
    logic        we;
    logic        ill;
    logic        chk_a0;
    logic        chk_a1;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   n_run = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] op, input logic [1:0] sz, input logic m64,
                      input logic zx, input logic pre, input logic [63:0] base,
                      input logic [63:0] idx, input logic [1:0] scl,
                      input logic [4:0] imm, input logic [1:0] pimm,
                      input logic [4:0] rd, input logic [4:0] rd2,
                      input logic [4:0] rs, input string tag);
    exp_t e;
    logic [63:0] off;
    logic dw;
    dw = (sz == 2'd3) && !m64;
    case (op)
      3'd0, 3'd1: e.ill = dw;
      3'd2:       e.ill = dw || (rd == rs);
      3'd3:       e.ill = dw;
      3'd4:       e.ill = dw || (sz < 2'd2) || (rs == rd) || (rs == rd2) || (rd == rd2);
      3'd5:       e.ill = dw || (sz < 2'd2);
      default:    e.ill = 1'b1;
    endcase
    e.a1 = '0; e.wb = '0; e.pv = 1'b0; e.we = 1'b0;
    e.chk_a0 = 1'b1; e.chk_a1 = 1'b0; e.tag = tag;
    if (op == 3'd2 || op == 3'd3) begin
      off  = {{59{imm[4]}}, imm} << scl;
      e.wb = base + off;
      e.a0 = pre ? base + off : base;
      e.we = !e.ill;
    end else if (op == 3'd4 || op == 3'd5) begin
      e.a0 = base + ({62'd0, pimm} << ((sz == 2'd3) ? 4 : 3));
      e.a1 = e.a0 + ((sz == 2'd3) ? 64'd8 : 64'd4);
      e.pv = !e.ill;
      e.chk_a1 = 1'b1;
    end else begin
      off  = zx ? {32'd0, idx[31:0]} : idx;
      e.a0 = base + (off << scl);
      e.chk_a0 = (op <= 3'd1);
    end
    @(negedge clk_i);
    req_valid_i = 1'b1; op_i = op; size_i = sz; mode64_i = m64;
    zext_idx_i = zx; pre_inc_i = pre; base_i = base; index_i = idx;
    scale_i = scl; inc_imm_i = imm; pair_imm_i = pimm;
    rd_i = rd; rd2_i = rd2; rs_base_i = rs;
    q.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk_i);
    req_valid_i = 1'b0;
  endtask

  // monitor: results due one edge after the strobe
  initial begin
    forever begin
      @(posedge clk_i);
      #2;
      if (rst_ni && vld_o) begin
        if (q.size() == 0) begin
          n_run++; n_fail++;
          $display("FAIL R2 unexpected vld_o actual=1 expected=0");
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(e.tag, "illegal_o", 64'(illegal_o), 64'(e.ill));
          chk(e.tag, "wb_en_o", 64'(wb_en_o), 64'(e.we));
          chk(e.tag, "pair_vld_o", 64'(pair_vld_o), 64'(e.pv));
          if (e.chk_a0) chk(e.tag, "addr0_o", addr0_o, e.a0);
          if (e.chk_a1) chk(e.tag, "addr1_o", addr1_o, e.a1);
          if (e.we) chk(e.tag, "wb_data_o", wb_data_o, e.wb);
        end
      end
    end
  end

  initial begin
    #800000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #2;
    chk("R1", "vld_o in reset", 64'(vld_o), 64'd0);
    chk("R1", "wb_en_o in reset", 64'(wb_en_o), 64'd0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(posedge clk_i); #2;
    chk("R1", "vld_o idle", 64'(vld_o), 64'd0);
    chk("R1", "flags idle", {61'd0, pair_vld_o, wb_en_o, illegal_o}, 64'd0);

    // R3 indexed, all scales, negative index wraps
    for (int s = 0; s < 4; s++)
      send(3'd0, 2'd3, 1'b1, 1'b0, 1'b0, 64'h0000_1000_0000_0000,
           64'hFFFF_FFFF_FFFF_FFF0, 2'(s), 5'd0, 2'd0, 5'd1, 5'd2, 5'd3, "R3");
    send(3'd1, 2'd1, 1'b1, 1'b0, 1'b0, 64'h10, 64'h8000_0000_0000_0001, 2'd1,
         5'd0, 2'd0, 5'd3, 5'd0, 5'd3, "R3");
    // R4 zero-extended index
    send(3'd0, 2'd2, 1'b1, 1'b1, 1'b0, 64'h100, 64'hDEAD_BEEF_8000_0004, 2'd2,
         5'd0, 2'd0, 5'd1, 5'd0, 5'd2, "R4");
    send(3'd1, 2'd0, 1'b1, 1'b1, 1'b0, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 2'd3,
         5'd0, 2'd0, 5'd1, 5'd0, 5'd2, "R4");
    // R5/R6 increment, signed immediate
    send(3'd2, 2'd3, 1'b1, 1'b0, 1'b1, 64'h2000, 64'h0, 2'd3, 5'b10000, 2'd0,
         5'd5, 5'd0, 5'd6, "R5 R6 pre neg");
    send(3'd2, 2'd2, 1'b1, 1'b0, 1'b0, 64'h2000, 64'h0, 2'd2, 5'd15, 2'd0,
         5'd5, 5'd0, 5'd6, "R5 R6 post pos");
    send(3'd3, 2'd0, 1'b1, 1'b0, 1'b0, 64'h8, 64'h0, 2'd0, 5'b11111, 2'd0,
         5'd7, 5'd0, 5'd7, "R7 inc store same regs legal");
    send(3'd2, 2'd1, 1'b1, 1'b0, 1'b1, 64'h40, 64'h0, 2'd1, 5'd2, 2'd0,
         5'd9, 5'd0, 5'd9, "R7 R11 inc load clash");
    // R8 pairs
    send(3'd4, 2'd3, 1'b1, 1'b0, 1'b0, 64'h1000, 64'h0, 2'd0, 5'd0, 2'd3,
         5'd1, 5'd2, 5'd3, "R8 dw pair");
    send(3'd5, 2'd2, 1'b1, 1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFC, 64'h0, 2'd0,
         5'd0, 2'd2, 5'd1, 5'd2, 5'd3, "R8 w pair wrap");
    // R9 pair conflicts
    send(3'd4, 2'd2, 1'b1, 1'b0, 1'b0, 64'h100, 64'h0, 2'd0, 5'd0, 2'd1,
         5'd4, 5'd2, 5'd4, "R9 base eq rd");
    send(3'd4, 2'd2, 1'b1, 1'b0, 1'b0, 64'h100, 64'h0, 2'd0, 5'd0, 2'd1,
         5'd1, 5'd4, 5'd4, "R9 base eq rd2");
    send(3'd4, 2'd3, 1'b1, 1'b0, 1'b0, 64'h100, 64'h0, 2'd0, 5'd0, 2'd1,
         5'd6, 5'd6, 5'd4, "R9 rd eq rd2");
    send(3'd5, 2'd3, 1'b1, 1'b0, 1'b0, 64'h100, 64'h0, 2'd0, 5'd0, 2'd1,
         5'd4, 5'd4, 5'd4, "R9 pair store legal");
    idle();
    @(posedge clk_i); #2;
    chk("R2", "vld_o after idle", 64'(vld_o), 64'd0);
    // R10 32-bit mode
    send(3'd0, 2'd3, 1'b0, 1'b0, 1'b0, 64'h0, 64'h4, 2'd0, 5'd0, 2'd0,
         5'd1, 5'd0, 5'd2, "R10 idx dw");
    send(3'd3, 2'd3, 1'b0, 1'b0, 1'b1, 64'h0, 64'h0, 2'd0, 5'd1, 2'd0,
         5'd1, 5'd0, 5'd2, "R10 R11 inc dw");
    send(3'd5, 2'd3, 1'b0, 1'b0, 1'b0, 64'h0, 64'h0, 2'd0, 5'd0, 2'd0,
         5'd1, 5'd3, 5'd2, "R10 R11 pair dw");
    send(3'd3, 2'd2, 1'b0, 1'b0, 1'b1, 64'h10, 64'h0, 2'd2, 5'd1, 2'd0,
         5'd1, 5'd0, 5'd2, "R10 inc w legal");
    // R12 reserved ops and bad pair size
    send(3'd6, 2'd0, 1'b1, 1'b0, 1'b0, 64'h0, 64'h0, 2'd0, 5'd0, 2'd0,
         5'd1, 5'd2, 5'd3, "R12 op6");
    send(3'd7, 2'd2, 1'b1, 1'b0, 1'b0, 64'h0, 64'h0, 2'd0, 5'd0, 2'd0,
         5'd1, 5'd2, 5'd3, "R12 op7");
    send(3'd5, 2'd1, 1'b1, 1'b0, 1'b0, 64'h0, 64'h0, 2'd0, 5'd0, 2'd1,
         5'd1, 5'd2, 5'd3, "R12 pair half");
    idle();
    repeat (3) @(posedge clk_i);
    #2;
    chk("R2", "queue drained", 64'(q.size()), 64'd0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule